// File: doc/BRIEF.md
# Programmable raster timing generator

This block produces the scan timing for a raster display. A pixel counter steps across each line and a line counter steps down each frame. Comparators derive horizontal and vertical sync, horizontal and vertical blanking, and an active-video flag from the two counts. The current pixel and line coordinates are also brought out, and they are meaningful only while active video is high.

Every edge of the waveform comes from a run-time parameter rather than from a fixed video mode. Each axis has four parameters: its total, where blanking begins, where sync begins and where sync ends. A ninth setting chooses the sync polarity for each axis. All nine are written through a simple write port into a shadow bank. The working copy is refreshed from the shadow bank only as a frame closes, so a picture is never torn by a half-applied mode change.

The reset values of all eight counts are module parameters. Their defaults describe a 640 by 480 picture at about 60 frames per second with a 25 MHz pixel clock, which is a line of roughly 32 µs. Both totals must be programmed to at least 2.

Top module: `raster_timing_gen`

## Requirements
- R1: `pixelX` counts up by one each clock from 0 and returns to 0 on the clock after it equals the active horizontal total minus one.
- R2: `lineY` increments on each pixel-counter wrap, and returns to 0 when the pixel counter wraps while `lineY` equals the active vertical total minus one; it holds at all other times.
- R3: `hBlank` is 1 exactly when `pixelX` is at or above the horizontal blank start. The unflipped horizontal sync is true exactly when the horizontal sync start ≤ `pixelX` < the horizontal sync end.
- R4: `vBlank` and the unflipped vertical sync follow the same rules as R3, using `lineY` and the three vertical parameters.
- R5: The polarity setting at address 8 holds two bits, bit 0 for horizontal and bit 1 for vertical. When a bit is 1, sync is driven high during the sync interval. When a bit is 0, sync is driven low during the interval and is high elsewhere.
- R6: `activeVideo` is 1 exactly when both `hBlank` and `vBlank` are 0.
- R7: A write stores `cfgData` in the shadow slot selected by `cfgAddr`. The slots are 0 h-total, 1 h-blank start, 2 h-sync start, 3 h-sync end, 4 v-total, 5 v-blank start, 6 v-sync start, 7 v-sync end and 8 polarity. The working set takes the whole shadow bank only on the clock at which a frame ends, and both counters restart at 0 on that clock.
- R8: A write to any address from 9 to 15 changes no output behaviour.
- R9: While `rstN` is low, both counters are 0, the working and shadow banks hold the parameter defaults, and both syncs are active-low.
- R10: A write issued in the frame-ending cycle lands only in the shadow bank. The frame that starts next still uses the shadow contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Parameter write strobe |
| cfgAddr | input | ADDR_W (4) | Parameter slot select |
| cfgData | input | COORD_W (12) | Parameter write value |
| hSync | output | 1 | Horizontal sync, polarity per setting |
| vSync | output | 1 | Vertical sync, polarity per setting |
| hBlank | output | 1 | Horizontal blanking |
| vBlank | output | 1 | Vertical blanking |
| activeVideo | output | 1 | Visible-pixel flag |
| pixelX | output | COORD_W (12) | Current pixel count in the line |
| lineY | output | COORD_W (12) | Current line count in the frame |

## Verification
The pixel and line counters set every other output. A wrong count therefore shows at `pixelX` or `lineY` on the very next clock, and it skews blanking and sync in the same cycle. A shadow bank that is copied at the wrong moment leaves counts and edges intact until a line or frame boundary. The error then appears as a line of the wrong length or an edge at the wrong position, so the bench compares every cycle against a model and times whole lines just after frame boundaries. A stray decode of an unused address shows up only after the next frame boundary, which is why the random run covers several frames after each such write.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // strobes sent from the counter control to the parameter datapath
  typedef struct packed {
    logic lineEnd;
    logic frameEnd;
  } rtg_strobe_t;

  localparam int NUM_SLOTS  = 8;   // four per axis
  localparam int POL_ADDR   = 8;   // polarity slot
  localparam int AXIS_SLOTS = 4;
  localparam int OFS_TOTAL  = 0;
  localparam int OFS_BLANK  = 1;
  localparam int OFS_SSTART = 2;
  localparam int OFS_SEND   = 3;
endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] hTotal,
  input  logic [COORD_W-1:0] vTotal,
  output logic [COORD_W-1:0] hCount,
  output logic [COORD_W-1:0] vCount,
  output rtg_strobe_t        strobe
);
  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  always_comb begin
    strobe.lineEnd  = (hCount == hTotal - ONE);
    strobe.frameEnd = strobe.lineEnd && (vCount == vTotal - ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (strobe.frameEnd) begin
      hCount <= '0;
      vCount <= '0;
    end else if (strobe.lineEnd) begin
      hCount <= '0;
      vCount <= vCount + ONE;
    end else begin
      hCount <= hCount + ONE;
    end
  end
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 4,
  parameter int H_TOTAL = 800,
  parameter int H_BLANK = 640,
  parameter int H_SSTRT = 656,
  parameter int H_SEND  = 752,
  parameter int V_TOTAL = 525,
  parameter int V_BLANK = 480,
  parameter int V_SSTRT = 490,
  parameter int V_SEND  = 492
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [COORD_W-1:0] cfgData,
  input  rtg_strobe_t        strobe,
  input  logic [COORD_W-1:0] hCount,
  input  logic [COORD_W-1:0] vCount,
  output logic [COORD_W-1:0] hTotalAct,
  output logic [COORD_W-1:0] vTotalAct,
  output logic               hBlank,
  output logic               vBlank,
  output logic               hSync,
  output logic               vSync,
  output logic               activeVideo
);
  localparam logic [COORD_W-1:0] RST_VAL [NUM_SLOTS] = '{
    COORD_W'(H_TOTAL), COORD_W'(H_BLANK), COORD_W'(H_SSTRT), COORD_W'(H_SEND),
    COORD_W'(V_TOTAL), COORD_W'(V_BLANK), COORD_W'(V_SSTRT), COORD_W'(V_SEND)
  };

  logic [COORD_W-1:0] shadowReg [NUM_SLOTS];
  logic [COORD_W-1:0] activeReg [NUM_SLOTS];
  logic [1:0]         shadowPol, activePol;
  logic [1:0]         blankVec, syncVec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowReg[i] <= RST_VAL[i];
        activeReg[i] <= RST_VAL[i];
      end else begin
        if (strobe.frameEnd) activeReg[i] <= shadowReg[i];
        if (cfgWe && cfgAddr == ADDR_W'(i)) shadowReg[i] <= cfgData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPol <= 2'b00;
      activePol <= 2'b00;
    end else begin
      if (strobe.frameEnd) activePol <= shadowPol;
      if (cfgWe && cfgAddr == ADDR_W'(POL_ADDR)) shadowPol <= cfgData[1:0];
    end
  end

  // one comparator set per axis: 0 horizontal, 1 vertical
  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam int BASE = a * AXIS_SLOTS;
    logic [COORD_W-1:0] axisCount;
    logic               syncRaw;
    assign axisCount   = (a == 0) ? hCount : vCount;
    assign blankVec[a] = axisCount >= activeReg[BASE + OFS_BLANK];
    assign syncRaw     = (axisCount >= activeReg[BASE + OFS_SSTART]) &&
                         (axisCount <  activeReg[BASE + OFS_SEND]);
    assign syncVec[a]  = activePol[a] ? syncRaw : !syncRaw;
  end

  assign hTotalAct   = activeReg[OFS_TOTAL];
  assign vTotalAct   = activeReg[AXIS_SLOTS + OFS_TOTAL];
  assign hBlank      = blankVec[0];
  assign vBlank      = blankVec[1];
  assign hSync       = syncVec[0];
  assign vSync       = syncVec[1];
  assign activeVideo = ~|blankVec;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 4,
  parameter int H_TOTAL = 800,
  parameter int H_BLANK = 640,
  parameter int H_SSTRT = 656,
  parameter int H_SEND  = 752,
  parameter int V_TOTAL = 525,
  parameter int V_BLANK = 480,
  parameter int V_SSTRT = 490,
  parameter int V_SEND  = 492
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [COORD_W-1:0] cfgData,
  output logic               hSync,
  output logic               vSync,
  output logic               hBlank,
  output logic               vBlank,
  output logic               activeVideo,
  output logic [COORD_W-1:0] pixelX,
  output logic [COORD_W-1:0] lineY
);
  rtg_strobe_t        strobe;
  logic [COORD_W-1:0] hTotalAct, vTotalAct;
  logic [COORD_W-1:0] hCount, vCount;

  rtg_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hTotal(hTotalAct), .vTotal(vTotalAct),
    .hCount(hCount), .vCount(vCount), .strobe(strobe)
  );

  rtg_datapath #(
    .COORD_W(COORD_W), .ADDR_W(ADDR_W),
    .H_TOTAL(H_TOTAL), .H_BLANK(H_BLANK), .H_SSTRT(H_SSTRT), .H_SEND(H_SEND),
    .V_TOTAL(V_TOTAL), .V_BLANK(V_BLANK), .V_SSTRT(V_SSTRT), .V_SEND(V_SEND)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobe(strobe), .hCount(hCount), .vCount(vCount),
    .hTotalAct(hTotalAct), .vTotalAct(vTotalAct),
    .hBlank(hBlank), .vBlank(vBlank), .hSync(hSync), .vSync(vSync),
    .activeVideo(activeVideo)
  );

  assign pixelX = hCount;
  assign lineY  = vCount;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic [COORD_W-1:0] pixelX,
  input logic [COORD_W-1:0] lineY,
  input logic               hBlank,
  input logic               vSync,
  input logic [COORD_W-1:0] hTotalAct,
  input logic [COORD_W-1:0] vTotalAct
);
  // R1: away from a wrap the pixel count steps by exactly one
  p_pixel_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pixelX != '0) |-> (pixelX == $past(pixelX) + COORD_W'(1)));

  // R2: the line count only moves when the pixel count restarts
  p_line_move_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lineY != $past(lineY)) |-> (pixelX == '0));

  // R3: once blanking starts in a line it lasts to the line end
  p_hblank_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hBlank) && pixelX != '0) |-> hBlank);

  // R4: vertical sync edges fall only on line starts
  p_vsync_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (vSync != $past(vSync)) |-> (pixelX == '0));

  // R7: working totals change only where a frame begins
  p_params_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pixelX != '0 || lineY != '0) |-> ($stable(hTotalAct) && $stable(vTotalAct)));
endmodule

bind raster_timing_gen rtg_checker #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .pixelX(pixelX), .lineY(lineY), .hBlank(hBlank),
  .vSync(vSync), .hTotalAct(hTotalAct), .vTotalAct(vTotalAct)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int CW = 12;
  localparam int AW = 4;
  localparam int RST_P [9] = '{12, 9, 10, 11, 6, 5, 5, 6, 0};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [CW-1:0] cfgData = '0;
  logic          hSync, vSync, hBlank, vBlank, activeVideo;
  logic [CW-1:0] pixelX, lineY;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  int  mH, mV;
  int  mAct [9];
  int  mSh [9];

  always #4 clk = ~clk;

  raster_timing_gen #(
    .COORD_W(CW), .ADDR_W(AW),
    .H_TOTAL(12), .H_BLANK(9), .H_SSTRT(10), .H_SEND(11),
    .V_TOTAL(6), .V_BLANK(5), .V_SSTRT(5), .V_SEND(6)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .hSync(hSync), .vSync(vSync), .hBlank(hBlank), .vBlank(vBlank),
    .activeVideo(activeVideo), .pixelX(pixelX), .lineY(lineY)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", req, act, exp, mH, mV);
    end
  endtask

  function automatic int expSync(input int cnt, input int ss, input int se, input int pol);
    int raw = (cnt >= ss && cnt < se) ? 1 : 0;
    return pol ? raw : 1 - raw;
  endfunction

  task automatic compareAll();
    int hb = (mH >= mAct[1]) ? 1 : 0;
    int vb = (mV >= mAct[5]) ? 1 : 0;
    chk("R1 pixelX", int'(pixelX), mH);
    chk("R2 lineY", int'(lineY), mV);
    chk("R3 hBlank", int'(hBlank), hb);
    chk("R4 vBlank", int'(vBlank), vb);
    chk("R3 R5 hSync", int'(hSync), expSync(mH, mAct[2], mAct[3], mAct[8] & 1));
    chk("R4 R5 vSync", int'(vSync), expSync(mV, mAct[6], mAct[7], (mAct[8] >> 1) & 1));
    chk("R6 activeVideo", int'(activeVideo), (hb == 0 && vb == 0) ? 1 : 0);
  endtask

  function automatic bit modelFrameEnd();
    return (mH == mAct[0] - 1) && (mV == mAct[4] - 1);
  endfunction

  // called at a falling edge: check, drive, advance model and one clock
  task automatic step(input bit we, input int addr, input int data);
    bit lineEnd = (mH == mAct[0] - 1);
    bit frameEnd = modelFrameEnd();
    compareAll();
    cfgWe = we;
    cfgAddr = AW'(addr);
    cfgData = CW'(data);
    if (frameEnd) for (int i = 0; i < 9; i++) mAct[i] = mSh[i];
    if (we && addr == 8) mSh[8] = data & 3;
    else if (we && addr < 8) mSh[addr] = data & 12'hfff;
    if (frameEnd) begin mH = 0; mV = 0; end
    else if (lineEnd) begin mH = 0; mV = mV + 1; end
    else mH = mH + 1;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  // length of the line starting now (must be called with pixelX == 0)
  task automatic measureLine(output int len);
    len = 0;
    do begin
      step(1'b0, 0, 0);
      len++;
    end while (pixelX != '0 && len < 4000);
  endtask

  task automatic runToFrameEnd();
    int guard = 0;
    while (!modelFrameEnd() && guard < 100000) begin
      step(1'b0, 0, 0);
      guard++;
    end
  endtask

  task automatic programRandom();
    int p [9];
    p[0] = $urandom_range(20, 8);
    p[1] = $urandom_range(p[0] - 1, 2);
    p[2] = $urandom_range(p[0] - 1, 0);
    p[3] = $urandom_range(p[0], p[2]);
    p[4] = $urandom_range(10, 4);
    p[5] = $urandom_range(p[4] - 1, 1);
    p[6] = $urandom_range(p[4] - 1, 0);
    p[7] = $urandom_range(p[4], p[6]);
    p[8] = $urandom_range(3, 0);
    for (int i = 0; i < 9; i++) begin
      step(1'b1, i, p[i]);
      if ($urandom_range(3, 0) == 0) step(1'b1, $urandom_range(15, 9), $urandom); // R8 junk
      idle($urandom_range(3, 0));
    end
  endtask

  initial begin
    int len, oldTot;
    void'($urandom(32'd20240611));
    mH = 0; mV = 0;
    for (int i = 0; i < 9; i++) begin mAct[i] = RST_P[i]; mSh[i] = RST_P[i]; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 pixelX in reset", int'(pixelX), 0);
    chk("R9 lineY in reset", int'(lineY), 0);
    chk("R9 hSync idle high", int'(hSync), 1);
    chk("R9 vSync idle high", int'(vSync), 1);
    chk("R9 activeVideo", int'(activeVideo), 1);
    rstN = 1'b1;
    idle(80);  // R1 R2 R3 R4 on default timing, frame wraps included

    // R7: mid-frame write of h-total waits for the frame end
    runToFrameEnd();
    step(1'b0, 0, 0);
    idle(int'(RST_P[0]));           // now at start of line 1
    step(1'b1, 0, 17);
    idle(int'(RST_P[0]) - 1);       // back at pixel 0 of line 2
    measureLine(len);
    chk("R7 line length before frame end", len, RST_P[0]);
    runToFrameEnd();
    step(1'b0, 0, 0);
    measureLine(len);
    chk("R7 line length after frame end", len, 17);

    // R8: only junk addresses written across a full frame
    for (int a = 9; a < 16; a++) step(1'b1, a, 12'h003);
    runToFrameEnd();
    step(1'b0, 0, 0);
    measureLine(len);
    chk("R8 junk writes leave h-total", len, 17);

    // R10: write issued in the frame-ending cycle
    runToFrameEnd();
    oldTot = mSh[0];
    step(1'b1, 0, 9);
    measureLine(len);
    chk("R10 next frame keeps earlier shadow", len, oldTot);
    runToFrameEnd();
    step(1'b0, 0, 0);
    measureLine(len);
    chk("R10 following frame takes the write", len, 9);

    // R5: polarity both high, then random programming
    step(1'b1, 8, 3);
    runToFrameEnd();
    idle(60);
    for (int r = 0; r < 25; r++) begin
      programRandom();
      idle(450);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule